// File: doc/BRIEF.md
# Lane Parity Checker and Generator

This block checks and generates parity for one port of a dual-port buffer. It treats a 36-bit port word as four 9-bit lanes. Bits 0..8 form lane 0, bits 9..17 lane 1, bits 18..26 lane 2 and bits 27..35 lane 3. In each lane the top bit (bit 8, 17, 26 or 35) is the parity bit and the lower eight bits are data. Incoming bus words are checked against odd or even parity. The result is an active-low error flag. The flag is advisory only: it never blocks or alters a transfer.

On reads, the block can replace each lane's parity bit with a freshly computed one. One lane tree is shared between checking the bus and generating parity for mailbox reads. While such a read is under way the tree is busy with the read word, so the error flag is held at its no-error level.

A parameter picks the variant for each side. The writing side generates parity only for mailbox reads. The reading side generates it for every read. The block is purely combinational.

Top module: `parity_lane_unit`

## Requirements
- R1: With even parity selected (`oddSel`=0), a lane passes when the XOR of its nine bits is 0. The lanes are bits [8:0], [17:9], [26:18] and [35:27].
- R2: With odd parity selected (`oddSel`=1), a lane passes when the XOR of its nine bits is 1.
- R3: `parErrN` is 0 when at least one lane of `busIn` fails, and 1 when all four pass. This holds unless R8 applies.
- R4: When generation applies, `readOut` equals `readData`, except that bits 8, 17, 26 and 35 are replaced. Each new bit is the XOR of that lane's eight data bits for even parity, or its inverse for odd parity.
- R5: With `genReq`=0, `readOut` equals `readData` bit for bit, stored parity bits included.
- R6: With `GEN_ALL_READS`=0, generation applies only to mailbox reads (`mailSel`=1). Other reads pass `readData` through unchanged.
- R7: With `GEN_ALL_READS`=1, generation applies to every read, whether `mailSel` is 0 or 1.
- R8: A mailbox read with generation holds `parErrN` at 1 whatever `busIn` carries. Such a read means `chipSelN`=0, `enable`=1, `writeSel`=0, `mailSel`=1 and `genReq`=1.
- R9: Generation applies only during a read (`chipSelN`=0, `enable`=1, `writeSel`=0). Otherwise `readOut` equals `readData`.
- R10: Checking is passive. `busIn` never affects `readOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chipSelN | input | 1 | Port select, active low |
| enable | input | 1 | Transfer enable, active high |
| writeSel | input | 1 | 1 = write, 0 = read |
| mailSel | input | 1 | 1 = mailbox access, 0 = queue access |
| genReq | input | 1 | Parity generation request for reads |
| oddSel | input | 1 | 1 = odd parity, 0 = even parity |
| busIn | input | 36 | Word arriving on the port bus, to be checked |
| readData | input | 36 | Word chosen for output by the port |
| readOut | output | 36 | Outgoing word, parity bits replaced when generating |
| parErrN | output | 1 | Parity error flag, low on a failing lane |

## Verification
The checker module evaluates its properties whenever the inputs change. It confirms that the data bits of every lane always pass through untouched. It confirms that generated words carry correct parity in every lane, and that the flag stays high during mailbox reads with generation. It also confirms pass-through whenever generation is off or no read is active.

Some behaviours can only be shown by the bench's directed scenarios. These are the flag's response to each single failing lane under both parity senses, and the different read sources of the two variants. They also include the point that bus contents cannot reach the read output.

// File: rtl/parity_lane_pkg.sv
package parity_lane_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef struct packed {
    logic shareToRead;  // shared tree looks at the read word
    logic genMail;      // replace parity bits from shared tree
    logic genQueue;     // replace parity bits from queue tree
    logic forceOk;      // hold error flag inactive
  } laneCtrl_t;
endpackage

// File: rtl/parity_lane_ctrl.sv
module parity_lane_ctrl
  import parity_lane_pkg::*;
#(
  parameter bit GEN_ALL_READS = 1'b0
) (
  input  logic       chipSelN,
  input  logic       enable,
  input  logic       writeSel,
  input  logic       mailSel,
  input  logic       genReq,
  output laneCtrl_t  strobes
);
  logic readActive;
  logic mailGen;

  always_comb begin
    readActive = !chipSelN && enable && !writeSel;
    mailGen    = readActive && mailSel && genReq;
    strobes.shareToRead = mailGen;
    strobes.genMail     = mailGen;
    strobes.forceOk     = mailGen;
    strobes.genQueue    = GEN_ALL_READS && readActive && !mailSel && genReq;
  end
endmodule

// File: rtl/parity_lane_datapath.sv
module parity_lane_datapath
  import parity_lane_pkg::*;
#(
  parameter int  NUM_LANES     = LANES,
  parameter int  LANE_BITS     = LANE_W,
  parameter bit  GEN_ALL_READS = 1'b0,
  localparam int DATA_BITS     = LANE_BITS - 1,
  localparam int BUS_W         = NUM_LANES * LANE_BITS
) (
  input  laneCtrl_t        strobes,
  input  logic             oddSel,
  input  logic [BUS_W-1:0] busIn,
  input  logic [BUS_W-1:0] readData,
  output logic [BUS_W-1:0] readOut,
  output logic             parErrN
);
  logic [NUM_LANES-1:0] laneFail;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] srcLane;
    logic [LANE_BITS-1:0] rdLane;
    logic                 sharedXor;
    logic                 sharedPar;
    logic                 queuePar;

    always_comb begin
      rdLane    = readData[g*LANE_BITS +: LANE_BITS];
      srcLane   = strobes.shareToRead ? rdLane : busIn[g*LANE_BITS +: LANE_BITS];
      sharedXor = ^srcLane[DATA_BITS-1:0];
      sharedPar = sharedXor ^ oddSel;
      laneFail[g] = (sharedXor ^ srcLane[LANE_BITS-1]) != oddSel;
    end

    if (GEN_ALL_READS) begin : g_queueTree
      assign queuePar = (^rdLane[DATA_BITS-1:0]) ^ oddSel;
    end else begin : g_noQueueTree
      assign queuePar = 1'b0;
    end

    always_comb begin
      readOut[g*LANE_BITS +: DATA_BITS] = rdLane[DATA_BITS-1:0];
      if (strobes.genMail)
        readOut[g*LANE_BITS + DATA_BITS] = sharedPar;
      else if (strobes.genQueue)
        readOut[g*LANE_BITS + DATA_BITS] = queuePar;
      else
        readOut[g*LANE_BITS + DATA_BITS] = rdLane[LANE_BITS-1];
    end
  end

  assign parErrN = strobes.forceOk || !(|laneFail);
endmodule

// File: rtl/parity_lane_unit.sv
module parity_lane_unit
  import parity_lane_pkg::*;
#(
  parameter bit GEN_ALL_READS = 1'b0
) (
  input  logic              chipSelN,
  input  logic              enable,
  input  logic              writeSel,
  input  logic              mailSel,
  input  logic              genReq,
  input  logic              oddSel,
  input  logic [WORD_W-1:0] busIn,
  input  logic [WORD_W-1:0] readData,
  output logic [WORD_W-1:0] readOut,
  output logic              parErrN
);
  laneCtrl_t strobes;

  parity_lane_ctrl #(.GEN_ALL_READS(GEN_ALL_READS)) uCtrl (
    .chipSelN(chipSelN), .enable(enable), .writeSel(writeSel),
    .mailSel(mailSel), .genReq(genReq), .strobes(strobes)
  );

  parity_lane_datapath #(
    .NUM_LANES(LANES), .LANE_BITS(LANE_W), .GEN_ALL_READS(GEN_ALL_READS)
  ) uData (
    .strobes(strobes), .oddSel(oddSel), .busIn(busIn),
    .readData(readData), .readOut(readOut), .parErrN(parErrN)
  );
endmodule

// File: rtl/parity_lane_chk.sv
module parity_lane_chk
  import parity_lane_pkg::*;
#(
  parameter bit GEN_ALL_READS = 1'b0
) (
  input logic              chipSelN,
  input logic              enable,
  input logic              writeSel,
  input logic              mailSel,
  input logic              genReq,
  input logic              oddSel,
  input logic [WORD_W-1:0] busIn,
  input logic [WORD_W-1:0] readData,
  input logic [WORD_W-1:0] readOut,
  input logic              parErrN
);
  logic isRead;
  logic mbGen;
  logic anyGen;
  logic [WORD_W-1:0] dataMask;

  always_comb begin
    isRead = !chipSelN && enable && !writeSel;
    mbGen  = isRead && mailSel && genReq;
    anyGen = mbGen || (GEN_ALL_READS && isRead && genReq);
    dataMask = '1;
    for (int k = 0; k < LANES; k++) dataMask[k*LANE_W + LANE_W - 1] = 1'b0;

    // R8
    forced_flag_chk: assert (!mbGen || parErrN);
    // R4
    data_bits_chk: assert ((readOut & dataMask) == (readData & dataMask));
    // R5
    gen_off_chk: assert (genReq || readOut == readData);
    // R9
    no_read_chk: assert (isRead || readOut == readData);
    // R4
    for (int k = 0; k < LANES; k++) begin
      gen_parity_chk: assert (!anyGen || ((^readOut[k*LANE_W +: LANE_W]) == oddSel));
    end
  end
endmodule

bind parity_lane_unit parity_lane_chk #(.GEN_ALL_READS(GEN_ALL_READS)) uChk (.*);

// File: tb/tb_parity_lane_unit.sv
`timescale 1ns/1ps
module tb_parity_lane_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic chipSelN, enable, writeSel, mailSel, genReq, oddSel;
  logic [35:0] busIn, readData;
  logic [35:0] outA, outB;
  logic errA, errB;
  int total = 0;
  int bad = 0;

  parity_lane_unit #(.GEN_ALL_READS(1'b0)) dut (
    .chipSelN(chipSelN), .enable(enable), .writeSel(writeSel), .mailSel(mailSel),
    .genReq(genReq), .oddSel(oddSel), .busIn(busIn), .readData(readData),
    .readOut(outA), .parErrN(errA)
  );
  parity_lane_unit #(.GEN_ALL_READS(1'b1)) dutB (
    .chipSelN(chipSelN), .enable(enable), .writeSel(writeSel), .mailSel(mailSel),
    .genReq(genReq), .oddSel(oddSel), .busIn(busIn), .readData(readData),
    .readOut(outB), .parErrN(errB)
  );

  // word whose lanes all satisfy the chosen parity
  function automatic logic [35:0] goodWord(input logic [31:0] d, input logic odd);
    logic [35:0] w;
    for (int k = 0; k < 4; k++) begin
      w[k*9 +: 8] = d[k*8 +: 8];
      w[k*9 + 8]  = (^d[k*8 +: 8]) ^ odd;
    end
    return w;
  endfunction

  function automatic logic [35:0] flipPar(input logic [35:0] w, input int lane);
    logic [35:0] r = w;
    r[lane*9 + 8] = ~r[lane*9 + 8];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic cs, input logic en, input logic wr, input logic mb,
                       input logic pg, input logic od, input logic [35:0] bi,
                       input logic [35:0] rd);
    @(posedge clk);
    chipSelN = cs; enable = en; writeSel = wr; mailSel = mb;
    genReq = pg; oddSel = od; busIn = bi; readData = rd;
    @(negedge clk);
  endtask

  task automatic tIdle;
    drive(1, 0, 1, 0, 0, 0, '0, '0);
    chk("R3 idle flag", {35'd0, errA}, 36'd1);
    chk("R5 idle out", outA, 36'd0);
  endtask

  task automatic tEven;
    logic [35:0] w = goodWord(32'hA5C3_7E19, 1'b0);
    drive(0, 1, 1, 0, 0, 0, w, '0);
    chk("R1 even all good", {35'd0, errA}, 36'd1);
    for (int k = 0; k < 4; k++) begin
      drive(0, 1, 1, 0, 0, 0, flipPar(w, k), '0);
      chk("R1 even lane fail", {35'd0, errA}, 36'd0);
      chk("R3 side B fail", {35'd0, errB}, 36'd0);
    end
  endtask

  task automatic tOdd;
    logic [35:0] w = goodWord(32'h1234_F00D, 1'b1);
    drive(0, 1, 1, 0, 0, 1, w, '0);
    chk("R2 odd all good", {35'd0, errA}, 36'd1);
    drive(0, 1, 1, 0, 0, 0, w, '0);
    chk("R2 odd word under even", {35'd0, errA}, 36'd0);
    drive(0, 1, 1, 0, 0, 1, flipPar(w, 2), '0);
    chk("R3 odd lane2 fail", {35'd0, errA}, 36'd0);
  endtask

  task automatic tGenA;
    logic [35:0] raw = 36'h0_FFFF_FFFF ^ 36'h1_2345_6789;
    drive(0, 1, 0, 1, 1, 0, '0, raw);
    chk("R4 side A mail gen even", outA, goodWord({raw[34:27], raw[25:18], raw[16:9], raw[7:0]}, 0));
    drive(0, 1, 0, 1, 1, 1, '0, raw);
    chk("R4 side A mail gen odd", outA, goodWord({raw[34:27], raw[25:18], raw[16:9], raw[7:0]}, 1));
    drive(0, 1, 0, 0, 1, 0, '0, raw);
    chk("R6 side A queue read unchanged", outA, raw);
  endtask

  task automatic tGenB;
    logic [35:0] raw = 36'hF_0F0F_3C5A;
    logic [31:0] d = {raw[34:27], raw[25:18], raw[16:9], raw[7:0]};
    drive(0, 1, 0, 0, 1, 1, '0, raw);
    chk("R7 side B queue gen", outB, goodWord(d, 1));
    drive(0, 1, 0, 1, 1, 0, '0, raw);
    chk("R7 side B mail gen", outB, goodWord(d, 0));
  endtask

  task automatic tGenOff;
    logic [35:0] raw = flipPar(goodWord(32'hDEAD_BEEF, 0), 1);
    drive(0, 1, 0, 1, 0, 0, '0, raw);
    chk("R5 A gen off", outA, raw);
    chk("R5 B gen off", outB, raw);
  endtask

  task automatic tForce;
    logic [35:0] badBus = flipPar(goodWord(32'h0, 0), 3);
    drive(0, 1, 0, 1, 1, 0, badBus, '0);
    chk("R8 A forced high", {35'd0, errA}, 36'd1);
    chk("R8 B forced high", {35'd0, errB}, 36'd1);
    drive(0, 1, 1, 1, 1, 0, badBus, '0);
    chk("R8 write not forced", {35'd0, errA}, 36'd0);
    drive(0, 1, 0, 0, 1, 0, badBus, '0);
    chk("R8 queue read not forced", {35'd0, errB}, 36'd0);
  endtask

  task automatic tNoRead;
    logic [35:0] raw = 36'h1_0000_0100;
    drive(1, 1, 0, 0, 1, 0, '0, raw);
    chk("R9 chip deselected", outB, raw);
    drive(0, 0, 0, 1, 1, 0, '0, raw);
    chk("R9 enable low", outA, raw);
    drive(0, 1, 1, 1, 1, 0, '0, raw);
    chk("R9 write cycle", outB, raw);
  endtask

  task automatic tPassive;
    logic [35:0] raw = 36'h5_5555_AAAA;
    drive(0, 1, 1, 0, 0, 0, 36'hF_FFFF_FFFF, raw);
    chk("R10 bus ones", outA, raw);
    drive(0, 1, 1, 0, 0, 0, 36'h0_1234_5678, raw);
    chk("R10 bus other", outA, raw);
    drive(0, 1, 0, 0, 1, 0, 36'hF_FFFF_FFFF, raw);
    chk("R10 B gen with bus", outB, goodWord({raw[34:27], raw[25:18], raw[16:9], raw[7:0]}, 0));
  endtask

  initial begin
    chipSelN = 1; enable = 0; writeSel = 1; mailSel = 0;
    genReq = 0; oddSel = 0; busIn = '0; readData = '0;
    tIdle; tEven; tOdd; tGenA; tGenB; tGenOff; tForce; tNoRead; tPassive;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule